// File: doc/BRIEF.md
# Stall-on-pending interrupt controller

This block collects event flags for a two-wire serial bus master and turns them into one interrupt line. The transfer engine sends single-cycle pulses for conditions such as a drained transmit queue, a full receive queue, completion of a send or a receive, reaching a programmed byte count, a missing acknowledge and lost arbitration. Each pulse sets a sticky bit in a status register. An enable mask chooses which of the set bits drive the interrupt line.

The block also holds the engine. While any status bit is set, a registered hold output tells the engine to pause. Software reads the status, services the cause, and then writes ones to a separate clear address. That write drops the bits and, one cycle later, the hold, so the engine resumes. Clearing an interrupt is therefore also the flow-control handshake between software and the engine.

The register port is a simple write strobe with address and data, plus a read address with a combinational read data output.

Top module: `stall_irq_ctrl`

## Requirements
- R1: After reset the status and enable registers read zero, and irq_o and hold_o are low.
- R2: A pulse on ev_i[k] sets status bit k at the next clock edge, whether or not the bit is enabled. The defined positions are: 9 transmit queue empty, 8 receive queue full, 7 send done, 6 receive done, 5 transmit count reached, 4 receive count reached, 2 missing acknowledge, 1 arbitration lost. Status reads at address 0x20.
- R3: Positions 0 and 3 are reserved. Pulses there never set a bit, and reserved bits and all bits above 9 read as zero.
- R4: A write to address 0x28 clears each status bit whose data bit is 1 and leaves the others unchanged. Writing all ones clears every bit.
- R5: If a pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: The enable mask is written and read at address 0x24. Only the defined positions of R2 are stored.
- R7: irq_o is high exactly when some status bit is set and its enable bit is also set. It follows the registers with no extra delay.
- R8: hold_o goes high one cycle after the status register becomes non-zero. It goes low one cycle after the status register becomes zero.
- R9: Writes to address 0x20 do not change the status. Address 0x28 reads as zero.
- R10: The receive-done bit (6) is set only by its own pulse. A missing-acknowledge pulse (bit 2) leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | NEV (10) | Single-cycle event pulses from the transfer engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (8) | Register write address |
| wr_data_i | input | DATA_W (32) | Register write data |
| rd_addr_i | input | ADDR_W (8) | Register read address |
| rd_data_o | output | DATA_W (32) | Register read data, combinational |
| irq_o | output | 1 | Interrupt line |
| hold_o | output | 1 | Pause request to the transfer engine |

## Verification
The bench goes after a pulse and a clear that hit the same bit in one cycle. A design that let the clear win would lose an event and release the engine too early. It checks the one-cycle lag of the hold output in both directions. A design that was one cycle fast or slow would stall the engine for the wrong number of cycles. It also checks that disabled bits still latch and still hold the engine, that reserved positions stay zero, that writes to the status address are ignored, and that a missing-acknowledge pulse never sets the receive-done bit. Getting any of these wrong would hide a pending cause or report one that never happened.

// File: rtl/stall_irq_ctrl.sv
module stall_irq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NEV = 10,
  parameter logic [NEV-1:0] DEF_MASK = 10'h3F6,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    ev_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              hold_o
);
  localparam int PAD = DATA_W - NEV;

  logic [NEV-1:0] sts_q, en_q, clr_mask, set_mask;
  logic hold_q;

  assign set_mask = ev_i & DEF_MASK;
  assign clr_mask = (wr_en_i && wr_addr_i == CLR_ADDR) ? wr_data_i[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      sts_q  <= (sts_q & ~clr_mask) | set_mask;
      hold_q <= |sts_q;
      if (wr_en_i && wr_addr_i == EN_ADDR)
        en_q <= wr_data_i[NEV-1:0] & DEF_MASK;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == STS_ADDR)     rd_data_o = {{PAD{1'b0}}, sts_q};
    else if (rd_addr_i == EN_ADDR) rd_data_o = {{PAD{1'b0}}, en_q};
  end

  assign irq_o  = |(sts_q & en_q);
  assign hold_o = hold_q;
endmodule

// File: rtl/stall_irq_ctrl_chk.sv
module stall_irq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NEV = 10,
  parameter logic [NEV-1:0] DEF_MASK = 10'h3F6,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    ev_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              irq_o,
  input logic              hold_o,
  input logic [NEV-1:0]    sts,
  input logic [NEV-1:0]    en
);
  AST_EV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    |(ev_i & DEF_MASK) |=> ((sts & $past(ev_i & DEF_MASK)) == $past(ev_i & DEF_MASK))); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~DEF_MASK) == '0 && (en & ~DEF_MASK) == '0); // R3
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts) & ~sts)) |-> $past(wr_en_i && wr_addr_i == CLR_ADDR)); // R4
  AST_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(sts != '0)); // R8
  AST_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(sts == '0)); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sts != '0 && en != '0)); // R7
endmodule

bind stall_irq_ctrl stall_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEV(NEV), .DEF_MASK(DEF_MASK), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .irq_o(irq_o), .hold_o(hold_o), .sts(sts_q), .en(en_q)
);

// File: tb/stall_irq_ctrl_tb.sv
`timescale 1ns/1ps
module stall_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [9:0] ev = 0;
  logic we = 0;
  logic [7:0] wa = 0, ra = 8'h20;
  logic [31:0] wd = 0, rd;
  logic irq, hold;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stall_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .ev_i(ev), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq), .hold_o(hold));

  int m_sts = 0, m_en = 0, m_hold = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts <= 0; m_en <= 0; m_hold <= 0;
    end else begin
      int nxt;
      nxt = m_sts;
      if (we && wa == 8'h28) nxt = nxt & ~int'(wd[9:0]);
      for (int k = 0; k < 10; k++)
        if (ev[k] && k != 0 && k != 3) nxt = nxt | (1 << k);
      m_hold <= (m_sts != 0) ? 1 : 0;
      m_sts <= nxt;
      if (we && wa == 8'h24) m_en <= int'(wd[9:0]) & 32'h3F6;
    end
  end

  function automatic int m_read(logic [7:0] a);
    if (a == 8'h20) return m_sts;
    if (a == 8'h24) return m_en;
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic [9:0] e, logic w, logic [7:0] a, logic [31:0] d,
                     logic [7:0] r, string tag);
    ev = e; we = w; wa = a; wd = d; ra = r;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rd_data"}, int'(rd), m_read(r));
    chk("R7 irq", int'(irq), ((m_sts & m_en) != 0) ? 1 : 0);
    chk("R8 hold", int'(hold), m_hold);
  endtask

  task automatic idle(string tag); cyc(0, 0, 0, 0, 8'h20, tag); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", int'(rd), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 hold", int'(hold), 0);
    rst_n = 1;
    @(negedge clk);
    ra = 8'h24; #1 chk("R1 enable", int'(rd), 0);

    for (int k = 0; k < 10; k++) begin
      if (k == 0 || k == 3) continue;
      cyc(10'(1 << k), 0, 0, 0, 8'h20, "R2");
      chk("R2 bit latched", int'(rd), 1 << k);
      chk("R2 no irq while disabled", int'(irq), 0);
      chk("R8 hold lags", int'(hold), 0);
      idle("R8");
      chk("R8 hold high", int'(hold), 1);
      cyc(0, 1, 8'h28, 32'hFFFF_FFFF, 8'h20, "R4");
      chk("R4 all ones clear", int'(rd), 0);
      chk("R8 hold still high", int'(hold), 1);
      idle("R8");
      chk("R8 hold low", int'(hold), 0);
    end

    cyc(10'h009, 0, 0, 0, 8'h20, "R3");
    chk("R3 reserved ignored", int'(rd), 0);
    idle("R3");
    chk("R3 no hold", int'(hold), 0);

    cyc(10'h3F6, 0, 0, 0, 8'h20, "R2");
    cyc(0, 1, 8'h28, 32'h0000_0030, 8'h20, "R4");
    chk("R4 partial clear", int'(rd), 32'h3C6);
    cyc(10'h080, 1, 8'h28, 32'h0000_0080, 8'h20, "R5");
    chk("R5 event wins", int'(rd), 32'h3C6);
    cyc(0, 1, 8'h20, 32'h0, 8'h28, "R9");
    chk("R9 clear reads zero", int'(rd), 0);
    ra = 8'h20; #1 chk("R9 status write ignored", int'(rd), 32'h3C6);
    cyc(0, 1, 8'h28, 32'hFFFF_FFFF, 8'h20, "R4");

    cyc(0, 1, 8'h24, 32'hFFFF_FFFF, 8'h24, "R6");
    chk("R6 enable stored mask", int'(rd), 32'h3F6);
    cyc(0, 1, 8'h24, 32'h0000_0004, 8'h24, "R6");
    chk("R6 enable single", int'(rd), 4);
    cyc(10'h002, 0, 0, 0, 8'h20, "R7");
    chk("R7 disabled bit no irq", int'(irq), 0);
    cyc(10'h004, 0, 0, 0, 8'h20, "R10");
    chk("R7 enabled bit irq", int'(irq), 1);
    chk("R10 rx done stays clear", int'(rd[6]), 0);
    chk("R10 no-ack set", int'(rd), 32'h006);
    cyc(0, 1, 8'h28, 32'h4, 8'h20, "R7");
    chk("R7 irq drops", int'(irq), 0);
    cyc(0, 1, 8'h28, 32'hFFFF_FFFF, 8'h20, "R4");

    for (int i = 0; i < 2000; i++) begin
      logic [9:0] e;
      logic w;
      logic [7:0] a;
      logic [7:0] r;
      e = (($urandom % 4) == 0) ? 10'($urandom) : 10'h0;
      w = ($urandom % 3) == 0;
      case ($urandom % 3) 0: a = 8'h20; 1: a = 8'h24; default: a = 8'h28; endcase
      case ($urandom % 3) 0: r = 8'h20; 1: r = 8'h24; default: r = 8'h28; endcase
      cyc(e, w, a, $urandom, r, "R2 R4 R5 R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule